// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block collects 128-bit interrupt vectors from on-chip sources and stores them in a circular buffer in system memory, where a host drains them. Each vector arrives over a valid/ready handshake. It leaves the block as four 32-bit memory writes at the ring's current write position. The source is held off until the whole write sequence has finished, so entries never interleave. A fifth write can follow, mirroring the write-pointer value to a separate writeback address, so the host can poll memory instead of reading a register.

Both pointers are byte offsets into the ring, and every entry is 16 bytes. The ring length is programmed as the log2 of its length in 32-bit words. The host consumes entries and moves the read pointer forward. The block raises its interrupt line when new entries land. If a new vector is accepted while the ring is full, the block writes it anyway and sets a sticky overflow flag in the write-pointer value. The host clears that flag through a control bit.

The vector payload is stored exactly as received, with no change to its layout:
- word 0 is bits [31:0];
- word 1 is bits [63:32];
- word 2 is bits [95:64];
- word 3 is bits [127:96].

Hosts normally find the source id in word 0 bits [7:0] and the source data in word 1 bits [27:0]. Word 2 carries the ring id in bits [7:0], the VM id in bits [15:8] and the address-space id in bits [31:16].

Top module: `ivring_writer`

## Requirements
- R1: After reset:
  - every register reads 0;
  - `vec_ready`, `mem_valid` and `irq` are low.
- R2: An accepted vector produces four memory writes, in order, at base*256 + wptr + 0, 4, 8 and 12. Word i carries `vec_data[32i+31:32i]`. While `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold steady.
- R3: The pointer advances by 16 after each vector, modulo the ring length. The ring length in bytes is 4 << size, with size clamped to MAX_LOG2. The pointer changes at no other time except through a pointer write.
- R4: When writeback is enabled (control bit 2), a fifth write follows the four words. Its address is {wb_hi[7:0], wb_lo[31:0]} and its data is the new write-pointer register value. When writeback is disabled, no fifth write is issued.
- R5: Acceptance and sequencing:
  - `vec_ready` is high only while the ring is enabled (control bit 0) and no sequence is in progress;
  - `vec_ready` stays low from acceptance until the last write of the sequence completes;
  - while the ring is disabled, a held `vec_valid` causes no memory write and no pointer change.
- R6: Overflow handling:
  - a vector accepted when (wptr+16) mod length equals rptr sets the overflow bit, bit 31 of the write-pointer value;
  - the vector is still written and the pointer still advances;
  - the bit stays set until control is written with bit 31 = 1.
- R7: Interrupt behaviour:
  - each completed vector sets a pending flag;
  - a host write to rptr clears the flag, unless rearm (control bit 3) is set and the new rptr differs from wptr, in which case the flag is set;
  - `irq` is pending AND interrupt enable (control bit 1).
- R8: Pointer writes:
  - a write to the wptr register takes effect only while the ring is disabled and idle, and is otherwise ignored;
  - rptr writes are masked to the ring length.
- R9: Register map, selected by `reg_addr`:
  - 0: control, with ring enable bit 0, interrupt enable bit 1, writeback enable bit 2, rearm bit 3, size [8:4] and overflow clear bit 31 (write-only, reads 0);
  - 1: base, holding address bits [39:8];
  - 2: rptr;
  - 3: wptr, with overflow in bit 31;
  - 4: wb_lo;
  - 5: wb_hi [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| vec_valid | input | 1 | Source offers a vector |
| vec_ready | output | 1 | Block accepts the vector this cycle |
| vec_data | input | 128 | Vector payload, word 0 in the low bits |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 40 | Byte address of the write |
| mem_data | output | 32 | Write data |
| irq | output | 1 | Interrupt line |

## Verification
The main function is exercised in several regimes:
- back-to-back vectors with memory always ready, which separates address and word-order errors from handshake errors;
- random memory back-pressure, which shows whether the sequence holds its address and data and keeps the source stalled;
- a ring wrap, which tests the modulo arithmetic;
- a two-entry fill past the read pointer, which tests overflow detection, its stickiness and the overflow bit appearing in the writeback word.

Read-pointer writes with rearm on and off, with pointers equal and unequal, tell the clear path apart from the re-assert path. Runs with writeback disabled and with the ring disabled show that no extra or stray memory writes occur.

// File: rtl/ivring_writer.sv
module ivring_writer #(
  parameter int MAX_LOG2 = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vec_valid,
  output logic         vec_ready,
  input  logic [127:0] vec_data,
  input  logic         reg_wr,
  input  logic [2:0]   reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  output logic         mem_valid,
  input  logic         mem_ready,
  output logic [39:0]  mem_addr,
  output logic [31:0]  mem_data,
  output logic         irq
);
  localparam int PW = MAX_LOG2 + 2;

  typedef enum logic [1:0] {S_IDLE, S_WORD, S_WB} state_t;
  state_t state;

  logic          ring_en, irq_en, wb_en, rearm;
  logic [4:0]    size_f, sz;
  logic [31:0]   base_q, wb_lo;
  logic [7:0]    wb_hi;
  logic [PW-1:0] rptr, wptr, nxt_ptr, mask, adv, rptr_new;
  logic          ovf, hit_q, pend, wb_q;
  logic [127:0]  vec_q;
  logic [1:0]    idx;
  logic          wr_ctl, wr_base, wr_rptr, wr_wptr, wr_wbl, wr_wbh;
  logic          accept, commit, ovf_clr, wptr_wr;
  logic [31:0]   wb_val;

  assign sz       = (size_f > 5'(MAX_LOG2)) ? 5'(MAX_LOG2) : size_f;
  assign mask     = {PW{1'b1}} >> (5'(MAX_LOG2) - sz);
  assign adv      = (wptr + PW'(16)) & mask;
  assign rptr_new = reg_wdata[PW-1:0] & mask;

  assign wr_ctl  = reg_wr && reg_addr == 3'd0;
  assign wr_base = reg_wr && reg_addr == 3'd1;
  assign wr_rptr = reg_wr && reg_addr == 3'd2;
  assign wr_wptr = reg_wr && reg_addr == 3'd3;
  assign wr_wbl  = reg_wr && reg_addr == 3'd4;
  assign wr_wbh  = reg_wr && reg_addr == 3'd5;
  assign ovf_clr = wr_ctl && reg_wdata[31];
  assign wptr_wr = wr_wptr && !ring_en && state == S_IDLE;

  assign vec_ready = ring_en && state == S_IDLE;
  assign accept    = vec_valid && vec_ready;
  assign mem_valid = state != S_IDLE;
  assign commit    = mem_ready && ((state == S_WB) ||
                     (state == S_WORD && idx == 2'd3 && !wb_q));

  assign wb_val   = {ovf | hit_q, {(31-PW){1'b0}}, nxt_ptr};
  assign mem_addr = (state == S_WB) ? {wb_hi, wb_lo}
                  : {base_q, 8'h00} + {{(40-PW){1'b0}}, wptr} + {35'd0, idx, 2'b00};
  assign mem_data = (state == S_WB) ? wb_val : vec_q[{idx, 5'b0} +: 32];
  assign irq      = irq_en && pend;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {23'd0, size_f, rearm, wb_en, irq_en, ring_en};
      3'd1:    reg_rdata = base_q;
      3'd2:    reg_rdata = {{(32-PW){1'b0}}, rptr};
      3'd3:    reg_rdata = {ovf, {(31-PW){1'b0}}, wptr};
      3'd4:    reg_rdata = wb_lo;
      3'd5:    reg_rdata = {24'd0, wb_hi};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_en <= 1'b0;
      irq_en  <= 1'b0;
      wb_en   <= 1'b0;
      rearm   <= 1'b0;
      size_f  <= 5'd0;
      base_q  <= 32'd0;
      wb_lo   <= 32'd0;
      wb_hi   <= 8'd0;
    end else begin
      if (wr_ctl) begin
        ring_en <= reg_wdata[0];
        irq_en  <= reg_wdata[1];
        wb_en   <= reg_wdata[2];
        rearm   <= reg_wdata[3];
        size_f  <= reg_wdata[8:4];
      end
      if (wr_base) base_q <= reg_wdata;
      if (wr_wbl)  wb_lo  <= reg_wdata;
      if (wr_wbh)  wb_hi  <= reg_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= 2'd0;
      vec_q   <= '0;
      nxt_ptr <= '0;
      hit_q   <= 1'b0;
      wb_q    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          vec_q   <= vec_data;
          nxt_ptr <= adv;
          hit_q   <= adv == rptr;
          wb_q    <= wb_en;
          idx     <= 2'd0;
          state   <= S_WORD;
        end
        S_WORD: if (mem_ready) begin
          if (idx == 2'd3) state <= wb_q ? S_WB : S_IDLE;
          idx <= idx + 2'd1;
        end
        S_WB: if (mem_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      ovf  <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (wptr_wr)     wptr <= reg_wdata[PW-1:0];
      else if (commit) wptr <= nxt_ptr;
      if (wr_rptr) rptr <= rptr_new;
      if (ovf_clr) ovf <= 1'b0;
      if (commit && hit_q) ovf <= 1'b1;
      if (commit)       pend <= 1'b1;
      else if (wr_rptr) pend <= rearm && (rptr_new != wptr);
      else if (wptr_wr) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/ivring_writer_chk.sv
module ivring_writer_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vec_valid,
  input logic          vec_ready,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [39:0]   mem_addr,
  input logic [31:0]   mem_data,
  input logic          irq,
  input logic          irq_en,
  input logic          ovf,
  input logic          ovf_clr,
  input logic [PW-1:0] wptr,
  input logic          wptr_wr,
  input logic          commit,
  input logic          wr_rptr
);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
  // R5
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(vec_valid && vec_ready));
  // R3
  wptr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wptr_wr && !commit |=> $stable(wptr));
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf);
  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(commit) || $past(wr_rptr) || $past(!irq_en));
endmodule

bind ivring_writer ivring_writer_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_ready(vec_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_data(mem_data), .irq(irq), .irq_en(irq_en), .ovf(ovf),
  .ovf_clr(ovf_clr), .wptr(wptr), .wptr_wr(wptr_wr), .commit(commit),
  .wr_rptr(wr_rptr)
);

// File: tb/sim_ivring_writer.sv
module sim_ivring_writer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         vec_valid = 1'b0;
  logic         vec_ready;
  logic [127:0] vec_data = '0;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_addr = 3'd0;
  logic [31:0]  reg_wdata = 32'd0;
  logic [31:0]  reg_rdata;
  logic         mem_valid;
  logic         mem_ready = 1'b1;
  logic [39:0]  mem_addr;
  logic [31:0]  mem_data;
  logic         irq;

  always #10 clk = ~clk;

  ivring_writer u0 (.*);

  int checks = 0;
  int fails = 0;
  logic [71:0] exp_q[$];
  logic [71:0] mon_e;
  logic        bp_on = 1'b0;
  logic [7:0]  lf = 8'h5a;

  logic [31:0] m_base = 32'h0012_3400;
  logic [39:0] m_wba  = 40'h7f_0000_1000;
  logic [31:0] m_wp = 0, m_rp = 0, m_mask = 63;
  logic        m_ovf = 1'b0, m_wb = 1'b1;
  logic [31:0] rd;

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    mem_ready <= #1 bp_on ? (lf[0] | lf[3]) : 1'b1;
  end

  always @(negedge clk) begin
    if (mem_valid) chk("R5 ready low during sequence", {39'd0, vec_ready}, 40'd0);
    if (mem_valid && mem_ready) begin
      if (exp_q.size() == 0) begin
        chk("R4 unexpected memory write", mem_addr, 40'h0);
      end else begin
        mon_e = exp_q.pop_front();
        chk("R2/R4 write address", mem_addr, mon_e[71:32]);
        chk("R2/R4 write data", {8'd0, mem_data}, {8'd0, mon_e[31:0]});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rdr(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #2;
    d = reg_rdata;
  endtask

  task automatic set_rp(input logic [31:0] v);
    wr(3'd2, v);
    m_rp = v & m_mask;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 200) begin
      @(negedge clk); n++;
    end
    if (exp_q.size() != 0) begin
      chk("R4 missing memory writes", 40'(exp_q.size()), 40'd0);
      exp_q.delete();
    end
    @(posedge clk); #2;
  endtask

  task automatic send_vec(input logic [7:0] src, input logic [27:0] sdata,
                          input logic [7:0] ring, input logic [7:0] vm, input logic [15:0] pas);
    logic [127:0] v;
    logic [31:0]  nxt;
    logic         hit;
    v = {32'hc0de_0000 | 32'(src), {ring, vm, pas} ^ 32'h0, {4'h9, sdata}, {24'hab_cd_ef, src}};
    v[95:64] = {pas, vm, ring};
    nxt = (m_wp + 16) & m_mask;
    hit = (nxt == m_rp);
    for (int i = 0; i < 4; i++)
      exp_q.push_back({{m_base, 8'h00} + 40'(m_wp) + 40'(4 * i), v[32*i +: 32]});
    m_ovf = m_ovf | hit;
    m_wp  = nxt;
    if (m_wb) exp_q.push_back({m_wba, {m_ovf, 31'(m_wp)}});
    @(posedge clk); #1;
    vec_valid = 1'b1; vec_data = v;
    forever begin
      @(negedge clk);
      if (vec_ready) break;
    end
    @(posedge clk); #1;
    vec_valid = 1'b0;
    drain();
  endtask

  function automatic logic [31:0] ctlw(input logic ring, input logic ie, input logic wb,
                                        input logic ra, input logic [4:0] sz, input logic clr);
    return {clr, 22'd0, sz, ra, wb, ie, ring};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    for (int a = 0; a < 6; a++) begin
      rdr(3'(a), rd);
      chk("R1 register reset value", {8'd0, rd}, 40'd0);
    end
    chk("R1 vec_ready reset", {39'd0, vec_ready}, 40'd0);
    chk("R1 mem_valid reset", {39'd0, mem_valid}, 40'd0);
    chk("R1 irq reset", {39'd0, irq}, 40'd0);

    wr(3'd1, m_base);
    wr(3'd4, m_wba[31:0]);
    wr(3'd5, {24'd0, m_wba[39:32]});
    wr(3'd0, ctlw(1, 1, 1, 0, 5'd4, 0));
    rdr(3'd0, rd); chk("R9 control readback", {8'd0, rd}, {8'd0, ctlw(1, 1, 1, 0, 5'd4, 0)});
    rdr(3'd5, rd); chk("R9 wb_hi readback", {8'd0, rd}, 40'h7f);
    rdr(3'd1, rd); chk("R9 base readback", {8'd0, rd}, {8'd0, m_base});

    send_vec(8'h11, 28'h1234567, 8'h01, 8'h02, 16'hbeef);
    rdr(3'd3, rd); chk("R3 wptr after one vector", {8'd0, rd}, 40'h10);
    chk("R7 irq after vector", {39'd0, irq}, 40'd1);

    bp_on = 1'b1;
    send_vec(8'h22, 28'h0abcdef, 8'h03, 8'h04, 16'h1234);
    send_vec(8'h33, 28'h0fffffff, 8'hff, 8'h00, 16'hffff);
    rdr(3'd3, rd); chk("R3 wptr after three vectors", {8'd0, rd}, 40'h30);
    set_rp(32'h30);
    chk("R7 irq cleared by equal rptr", {39'd0, irq}, 40'd0);

    send_vec(8'h44, 28'h0000001, 8'h05, 8'h06, 16'h0007);
    rdr(3'd3, rd); chk("R3 wptr wraps to zero", {8'd0, rd}, 40'h0);
    chk("R7 irq set again", {39'd0, irq}, 40'd1);
    set_rp(32'h10);
    chk("R7 irq cleared without rearm", {39'd0, irq}, 40'd0);
    wr(3'd0, ctlw(1, 1, 1, 1, 5'd4, 0));
    set_rp(32'h20);
    chk("R7 rearm re-asserts irq", {39'd0, irq}, 40'd1);
    wr(3'd0, ctlw(1, 0, 1, 1, 5'd4, 0));
    chk("R7 irq gated by enable", {39'd0, irq}, 40'd0);
    wr(3'd0, ctlw(1, 1, 1, 1, 5'd4, 0));
    chk("R7 irq back with enable", {39'd0, irq}, 40'd1);
    set_rp(32'h0);
    chk("R7 rearm rptr equal clears", {39'd0, irq}, 40'd0);
    set_rp(32'h67);
    rdr(3'd2, rd); chk("R8 rptr masked to ring", {8'd0, rd}, 40'h27);
    set_rp(32'h20);

    wr(3'd0, ctlw(1, 1, 0, 1, 5'd4, 0));
    m_wb = 1'b0;
    send_vec(8'h55, 28'h0555555, 8'h07, 8'h08, 16'h0909);
    rdr(3'd3, rd); chk("R4 wptr with writeback off", {8'd0, rd}, 40'h10);
    wr(3'd0, ctlw(1, 1, 1, 1, 5'd4, 0));
    m_wb = 1'b1;

    send_vec(8'h66, 28'h0666666, 8'h0a, 8'h0b, 16'h0c0c);
    rdr(3'd3, rd); chk("R6 overflow flagged", {8'd0, rd}, 40'h8000_0020);
    send_vec(8'h77, 28'h0777777, 8'h0d, 8'h0e, 16'h0f0f);
    rdr(3'd3, rd); chk("R6 overflow sticky, pointer advances", {8'd0, rd}, 40'h8000_0030);
    wr(3'd0, ctlw(1, 1, 1, 1, 5'd4, 1));
    m_ovf = 1'b0;
    rdr(3'd3, rd); chk("R6 overflow cleared", {8'd0, rd}, 40'h30);
    rdr(3'd0, rd); chk("R9 clear bit reads zero", {8'd0, rd}, {8'd0, ctlw(1, 1, 1, 1, 5'd4, 0)});

    wr(3'd3, 32'h0);
    rdr(3'd3, rd); chk("R8 wptr write ignored while enabled", {8'd0, rd}, 40'h30);
    wr(3'd0, ctlw(0, 1, 1, 1, 5'd4, 0));
    set_rp(32'h0);
    wr(3'd3, 32'h0);
    m_wp = 0;
    rdr(3'd3, rd); chk("R8 wptr reset while disabled", {8'd0, rd}, 40'h0);
    rdr(3'd2, rd); chk("R8 rptr reset while disabled", {8'd0, rd}, 40'h0);

    @(posedge clk); #1;
    vec_valid = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R5 no accept while disabled", {39'd0, vec_ready}, 40'd0);
    end
    @(posedge clk); #1;
    vec_valid = 1'b0;
    rdr(3'd3, rd); chk("R5 wptr unchanged while disabled", {8'd0, rd}, 40'h0);

    wr(3'd0, ctlw(1, 1, 1, 0, 5'd3, 0));
    m_mask = 31;
    send_vec(8'h88, 28'h0888888, 8'h10, 8'h11, 16'h1212);
    send_vec(8'h99, 28'h0999999, 8'h13, 8'h14, 16'h1515);
    rdr(3'd3, rd); chk("R6 two-entry ring full overflow", {8'd0, rd}, 40'h8000_0000);

    repeat (4) @(posedge clk);
    summary();
  end
endmodule